// File: doc/BRIEF.md
# Transmit Packet FIFO with Hysteresis Almost-Full

This block is a single-clock buffer that sits between a packet producer and a transmit scheduler. Each write stores one entry: a data word, the number of valid bytes in it, and a packet-end marker. An entry never mixes bytes from two packets, so the last word of a packet is usually only partly filled. With the default wide setting an entry carries up to 8 bytes on a 64-bit data path. The narrow setting carries up to 4 bytes on a 32-bit data path. The buffer holds 510 entries.

The read side is a valid/ready stream with show-ahead data. `rd_valid` is high whenever an entry is stored, and the head entry sits on the read outputs. An entry leaves in the cycle where `rd_valid` and `rd_ready` are both high. The scheduler may hold `rd_ready` low for as long as it likes; the head entry and its fields stay put. The write side is a plain strobe with no ready. The producer throttles on `almost_full_n`, which has separate assert and negate levels, both counted in free entries. When the producer writes into a full buffer, the word is lost and a sticky overflow bit records it. A synchronous clear input empties the buffer.

Top module: `tx_pkt_fifo`

## Requirements
- R1: Capacity is DEPTH (510) entries. Exactly that many accepted writes come out of an initially empty buffer.
- R2: Entries leave in write order. Each one returns the byte count and packet-end bit it was written with.
- R3: `rd_valid` is high exactly when at least one entry is stored. An entry is removed on a clock edge with `rd_valid` and `rd_ready` both high. `rd_ready` while empty has no effect.
- R4: `almost_full_n` goes low on the same edge that brings the free-entry count (DEPTH minus stored entries) to or below `af_assert_th`.
- R5: Once low, `almost_full_n` returns high only on the edge that makes the free count reach or exceed `af_negate_th`. While the free count lies strictly between the two thresholds, the flag keeps its previous value. The negate level must be above the assert level.
- R6: A write (`wr_en` high) on an edge where all DEPTH entries are stored is dropped, even if a read happens on the same edge. That edge sets `overflow`, which then stays high until clear or reset.
- R7: `clr` empties the buffer on the next edge, lowers `overflow` and raises `almost_full_n`. It takes priority over a write or read on the same edge.
- R8: After reset the buffer is empty: `rd_valid` 0, `almost_full_n` 1, `overflow` 0.
- R9: `rd_data` byte lane i occupies bits [8i+7:8i], and lane 0 carries the first byte. Lanes at or above the entry's byte count read as zero. The byte count is written 1 to 8 in wide mode (WIDE=1) and 1 to 4 in narrow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous datapath clear |
| af_assert_th | input | FW (9) | Free-entry level at which the flag asserts (static) |
| af_negate_th | input | FW (9) | Free-entry level at which the flag releases (static) |
| wr_en | input | 1 | Write strobe, one entry per cycle |
| wr_data | input | DW (64) | Entry data, lane 0 first |
| wr_bytes | input | CW (4) | Valid bytes in the entry |
| wr_eop | input | 1 | Entry ends a packet |
| rd_ready | input | 1 | Scheduler accepts the head entry |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | DW (64) | Head entry data, unused lanes zero |
| rd_bytes | output | CW (4) | Head entry byte count |
| rd_eop | output | 1 | Head entry ends a packet |
| almost_full_n | output | 1 | Active-low almost-full with hysteresis |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
The state that is hardest to reach from the ports is the full buffer. Getting there takes 510 back-to-back writes with no read. After that, the flag's hold band is reached only by draining one entry at a time. The stimulus fills the buffer completely and pushes two extra writes to raise the overflow bit. It then reads one entry per step and checks the flag at the free counts just inside and just at the negate level. A cycle-accurate model with a scoreboard checks every read entry and the flag after every edge.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  typedef enum logic [1:0] {
    OCC_HOLD = 2'd0,
    OCC_INC  = 2'd1,
    OCC_DEC  = 2'd2
  } occ_op_e;

  function automatic int lane_bytes(input bit wide);
    return wide ? 8 : 4;
  endfunction
endpackage

// File: rtl/tpf_store.sv
module tpf_store #(
  parameter int DEPTH = 510,
  parameter int AW    = 9,
  parameter int W     = 69
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tpf_ctrl.sv
module tpf_ctrl
  import tpf_pkg::*;
#(
  parameter int DEPTH = 510,
  parameter int AW    = 9,
  parameter int FW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          rd_ready,
  output logic          push,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [FW-1:0] occ,
  output logic [FW-1:0] occ_next,
  output logic          ovf
);
  logic    full, empty, pop;
  occ_op_e op;

  assign full  = (occ == FW'(DEPTH));
  assign empty = (occ == '0);
  assign push  = wr_en && !full && !clr;
  assign pop   = rd_ready && !empty && !clr;

  always_comb begin
    unique case ({push, pop})
      2'b10:   op = OCC_INC;
      2'b01:   op = OCC_DEC;
      default: op = OCC_HOLD;
    endcase
  end

  always_comb begin
    if (clr) occ_next = '0;
    else begin
      unique case (op)
        OCC_INC: occ_next = occ + 1'b1;
        OCC_DEC: occ_next = occ - 1'b1;
        default: occ_next = occ;
      endcase
    end
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
      ovf  <= 1'b0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      occ <= occ_next;
      if (wr_en && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/tpf_hyst.sv
module tpf_hyst #(
  parameter int FW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] free_next,
  input  logic [FW-1:0] th_assert,
  input  logic [FW-1:0] th_negate,
  output logic          flag_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag_n <= 1'b1;
    else if (free_next <= th_assert)     flag_n <= 1'b0;
    else if (free_next >= th_negate)     flag_n <= 1'b1;
  end
endmodule

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo
  import tpf_pkg::*;
#(
  parameter int DEPTH = 510,
  parameter bit WIDE  = 1'b1,
  localparam int BYTES = lane_bytes(WIDE),
  localparam int DW    = 8 * BYTES,
  localparam int CW    = $clog2(BYTES + 1),
  localparam int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [FW-1:0] af_assert_th,
  input  logic [FW-1:0] af_negate_th,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] wr_bytes,
  input  logic          wr_eop,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rd_bytes,
  output logic          rd_eop,
  output logic          almost_full_n,
  output logic          overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int W  = DW + CW + 1;

  logic          push;
  logic [AW-1:0] wptr, rptr;
  logic [FW-1:0] occ, occ_next, free_next;
  logic [W-1:0]  head;

  tpf_ctrl #(.DEPTH(DEPTH), .AW(AW), .FW(FW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_ready(rd_ready),
    .push(push), .wptr(wptr), .rptr(rptr), .occ(occ), .occ_next(occ_next),
    .ovf(overflow)
  );

  tpf_store #(.DEPTH(DEPTH), .AW(AW), .W(W)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wdata({wr_eop, wr_bytes, wr_data}),
    .raddr(rptr), .rdata(head)
  );

  assign free_next = FW'(DEPTH) - occ_next;

  tpf_hyst #(.FW(FW)) u_hyst (
    .clk(clk), .rst_n(rst_n), .free_next(free_next),
    .th_assert(af_assert_th), .th_negate(af_negate_th), .flag_n(almost_full_n)
  );

  assign rd_valid = (occ != '0);
  assign rd_eop   = head[W-1];
  assign rd_bytes = head[DW +: CW];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign rd_data[8*i +: 8] = (CW'(i) < rd_bytes) ? head[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
  parameter int DEPTH = 510,
  parameter int FW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          wr_en,
  input logic          rd_valid,
  input logic [FW-1:0] occ,
  input logic          af_n,
  input logic          ovf,
  input logic [FW-1:0] th_a,
  input logic [FW-1:0] th_n
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH); // R1
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_en && !clr) |=> !rd_valid); // R3
  AST_AF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((DEPTH - int'(occ)) <= int'(th_a)) |-> !af_n); // R4
  AST_AF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((DEPTH - int'(occ)) >= int'(th_n)) |-> af_n); // R5
  AST_AF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af_n) |-> ((DEPTH - int'(occ)) >= int'(th_n))); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R6
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ == '0 && !ovf && af_n)); // R7
endmodule

bind tx_pkt_fifo tpf_checker #(.DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_valid(rd_valid),
  .occ(occ), .af_n(almost_full_n), .ovf(overflow),
  .th_a(af_assert_th), .th_n(af_negate_th)
);

// File: tb/tx_pkt_fifo_bench.sv
module tx_pkt_fifo_bench;
  localparam int DEPTH = 510;
  localparam int BYTES = 8;
  localparam int DW = 64;
  localparam int CW = 4;
  localparam int FW = 9;
  localparam int W  = DW + CW + 1;
  localparam int TH_A = 4;
  localparam int TH_N = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clr, wr_en, wr_eop, rd_ready;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] wr_bytes;
  logic rd_valid, rd_eop, almost_full_n, overflow;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rd_bytes;

  tx_pkt_fifo u_tx_pkt_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .af_assert_th(FW'(TH_A)), .af_negate_th(FW'(TH_N)),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bytes(wr_bytes), .wr_eop(wr_eop),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_bytes(rd_bytes), .rd_eop(rd_eop),
    .almost_full_n(almost_full_n), .overflow(overflow)
  );

  logic [W-1:0] q[$];
  int  mcnt, popped, n_chk, n_err, seq;
  bit  maf, movf, mon_on, done;

  function automatic logic [DW-1:0] masked(input logic [DW-1:0] d, input int nb);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < BYTES; i++) if (i < nb) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model, built from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mcnt = 0; maf = 1'b1; movf = 1'b0;
    end else if (clr) begin
      q.delete(); mcnt = 0; maf = 1'b1; movf = 1'b0;
    end else begin
      bit pop, push;
      pop  = rd_ready && mcnt > 0;
      push = wr_en && mcnt < DEPTH;
      if (wr_en && mcnt == DEPTH) movf = 1'b1;
      if (pop) begin void'(q.pop_front()); mcnt--; popped++; end
      if (push) begin
        q.push_back({wr_eop, wr_bytes, masked(wr_data, int'(wr_bytes))});
        mcnt++;
      end
      if (DEPTH - mcnt <= TH_A) maf = 1'b0;
      else if (DEPTH - mcnt >= TH_N) maf = 1'b1;
    end
  end

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      chk(rd_valid == (mcnt > 0), "R3 rd_valid", rd_valid, mcnt > 0);
      if (rd_valid && q.size() > 0) begin
        chk(rd_data == q[0][DW-1:0], "R2 R9 rd_data", rd_data, q[0][DW-1:0]);
        chk(rd_bytes == q[0][DW +: CW], "R2 rd_bytes", rd_bytes, q[0][DW +: CW]);
        chk(rd_eop == q[0][W-1], "R2 rd_eop", rd_eop, q[0][W-1]);
      end
      chk(almost_full_n == maf, "R4 R5 almost_full_n", almost_full_n, maf);
      chk(overflow == movf, "R6 overflow", overflow, movf);
    end
  end

  task automatic step(input bit we, input int nb, input bit eop, input bit rr,
                      input bit cl);
    wr_en = we; rd_ready = rr; clr = cl; wr_eop = eop;
    wr_bytes = CW'(nb);
    wr_data = {~seq[31:0], seq[31:0] * 32'h0101_0103};
    if (we) seq++;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_ready = 1'b0; clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; wr_en = 1'b0; rd_ready = 1'b0;
    wr_eop = 1'b0; wr_bytes = '0; wr_data = '0; seq = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(rd_valid == 1'b0, "R8 rd_valid", rd_valid, 0);
    chk(almost_full_n == 1'b1, "R8 almost_full_n", almost_full_n, 1);
    chk(overflow == 1'b0, "R8 overflow", overflow, 0);
    mon_on = 1'b1;
    @(posedge clk); #1;

    // R2 R9: packets with partial tails, then drain
    for (int p = 0; p < 4; p++)
      for (int k = 0; k <= p; k++) step(1, (k == p) ? p + 1 : BYTES, k == p, 0, 0);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 0);
    // R3 read while empty has no effect
    chk(rd_valid == 1'b0, "R3 empty after drain", rd_valid, 0);
    step(1, 3, 1, 0, 0);
    chk(rd_valid == 1'b1, "R3 valid after write", rd_valid, 1);

    // streaming with back-pressure on the read side
    for (int i = 0; i < 40; i++) step(i % 3 != 2, (i % 8) + 1, i % 5 == 4, i % 4 != 1, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1, 0);

    // R1 R4: fill to capacity from empty
    popped = 0;
    for (int i = 0; i < DEPTH; i++) step(1, BYTES, i % 4 == 3, 0, 0);
    chk(almost_full_n == 1'b0, "R4 flag at full", almost_full_n, 0);
    // R6: writes while full dropped (one with a concurrent read)
    step(1, 5, 1, 0, 0);
    chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
    step(1, 6, 1, 1, 0);
    chk(rd_valid == 1'b1, "R6 still valid", rd_valid, 1);
    // R5: drain to just inside band, then to negate level
    for (int i = 0; i < TH_N - 2; i++) step(0, 0, 0, 1, 0);
    chk(almost_full_n == 1'b0, "R5 hold in band", almost_full_n, 0);
    step(0, 0, 0, 1, 0);
    chk(almost_full_n == 1'b1, "R5 release at negate", almost_full_n, 1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0);
    chk(popped == DEPTH, "R1 entries out", popped, DEPTH);
    chk(overflow == 1'b1, "R6 sticky after drain", overflow, 1);

    // R7 clear with concurrent write and read
    for (int i = 0; i < 20; i++) step(1, BYTES, 0, 0, 0);
    step(1, 2, 1, 1, 1);
    chk(rd_valid == 1'b0, "R7 empty after clr", rd_valid, 0);
    chk(overflow == 1'b0, "R7 overflow cleared", overflow, 0);
    chk(almost_full_n == 1'b1, "R7 flag high", almost_full_n, 1);
    step(1, 7, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    chk(rd_valid == 1'b0, "R7 reuse after clr", rd_valid, 0);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule